// File: doc/BRIEF.md
# Audio DMA Channel Register Block

This block holds the control and status registers of one channel of a descriptor-ring audio bus-master DMA engine. Software reaches it through a small byte-addressed register port with 32-bit data and byte enables. The port gives access to these registers:

- the descriptor list base;
- the current and last valid ring indices;
- a status register;
- the position inside the current buffer;
- the prefetched index;
- a control register.

Reads are registered and return their data on the cycle after the request.

A parent engine drives the block from the hardware side. It moves the current index to the next descriptor with a one-cycle advance strobe. It loads the position-in-buffer count, and it raises status causes with one-cycle set pulses. The block combines status and control into one interrupt request. It also drives the run bit back to the engine.

The status register mixes two kinds of bit. Some are write-one-to-clear event bits. Others are read-only condition bits that the block derives itself. A register-reset command in the control register clears the ring state and keeps the interrupt enables.

Top module: `aud_dma_chan_regs`

## Requirements
- R1: Registers sit in 32-bit words chosen by `addr[3:2]`:
  - word 0 (0x00) is the descriptor base;
  - word 1 (0x04) holds the current index in byte 0, the last valid index in byte 1 and status in bytes 2–3;
  - word 2 (0x08) holds position-in-buffer in bytes 0–1, the prefetched index in byte 2 and control in byte 3;
  - word 3 (0x0C) reads as zero.
  
  `rdData` is valid on the cycle after `rdEn`.
- R2: After power-on reset, word 0 and word 2 read 0 and word 1 reads 0x00030000.
- R3: Status bit 0 (halted) is read-only. It is 1 while control bit 0 (run) is clear, and it goes to 0 one cycle after run is set.
- R4: Status bit 1 is read-only and equals 1 exactly when the current index equals the last valid index. It follows every change of either index.
- R5: Status bits 2 (last-valid completion), 3 (completion) and 4 (FIFO error) are cleared by writing 1 to them. Writes to status bits 0 and 1 have no effect.
- R6: The pulses `setLvCompl`, `setCompl` and `setFifoErr` set status bits 2, 3 and 4. A set in the same cycle as a write-one-to-clear of that bit leaves the bit at 1.
- R7: `irq` is 1 when (status bit 2 and control bit 2) or (status bit 3 and control bit 4). Status bit 4 never raises `irq`.
- R8: Writing 1 to control bit 1 performs a register reset in that cycle:
  - the base, the current, last valid and prefetched indices, and the position count are cleared;
  - control bit 0 is cleared and control bits 2–4 keep their previous values;
  - control bit 1 always reads 0.
- R9: On `advance`, the current index takes the prefetched index, and the prefetched index increments modulo 32.
- R10: A 32-bit read of word 1 returns the current index, the last valid index and status, all sampled in the same cycle.
- R11: Byte enables select which bytes of the base are written. The last valid index (5 bits, bits 7:5 read 0) is written only through byte 1 of word 1. The current index, the prefetched index and the position count ignore software writes, and the position count is loaded only by `picbLoad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| wrEn | input | 1 | Register write request |
| rdEn | input | 1 | Register read request |
| addr | input | 4 | Byte address within the channel; bits 3:2 select the word |
| byteEn | input | 4 | Write byte enables |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| advance | input | 1 | Move to the next descriptor |
| picbLoad | input | 1 | Load position-in-buffer count |
| picbValue | input | 16 | Value for the position count |
| setCompl | input | 1 | Buffer completion event |
| setLvCompl | input | 1 | Last valid buffer completion event |
| setFifoErr | input | 1 | FIFO error event |
| irq | output | 1 | Interrupt request |
| runBm | output | 1 | Run bit to the engine |

## Verification
The indices are stepped through a ring walk that passes the last valid index and wraps the prefetched index past 31. This separates a correct modulo-32 advance from an off-by-one or a stuck index, and it shows the equality flag following the indices. Each status cause is raised with its enable off, then on, then cleared. The FIFO error case uses every enable set, which shows whether the interrupt gating is done per cause. A set that coincides with a clear shows whether the hardware event takes priority. A register reset issued with all enables on shows which control bits survive.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  localparam int RING_DEPTH = 32;
  localparam int IDX_W      = $clog2(RING_DEPTH);
  localparam int SR_W       = 5;
  localparam int CR_W       = 5;
  localparam int DATA_W     = 32;

  // Status bit positions
  localparam int SR_HALT  = 0;
  localparam int SR_EQ    = 1;
  localparam int SR_LVDONE = 2;
  localparam int SR_DONE  = 3;
  localparam int SR_FIFO  = 4;

  // Control bit positions
  localparam int CR_RUN   = 0;
  localparam int CR_RST   = 1;
  localparam int CR_LVIE  = 2;
  localparam int CR_FIE   = 3;
  localparam int CR_DONEIE = 4;

  localparam logic [CR_W-1:0] CR_KEEP  = 5'b11100;
  localparam logic [SR_W-1:0] SR_W1C   = 5'b11100;

  // Byte lanes of the status and control fields
  localparam int SR_LSB = 16;
  localparam int CR_LSB = 24;
  localparam int LVI_LSB = 8;

  typedef struct packed {
    logic [3:0]        baseBe;
    logic              lviWr;
    logic [SR_W-1:0]   srClr;
    logic              crWr;
    logic              regReset;
    logic [DATA_W-1:0] data;
    logic              rdEn;
    logic [1:0]        rdWord;
  } chanStrobes_t;
endpackage

// File: rtl/aud_dma_chan_ctrl.sv
module aud_dma_chan_ctrl
  import aud_dma_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [3:0]        byteEn,
  input  logic [DATA_W-1:0] wrData,
  output chanStrobes_t      strobes
);
  logic [1:0] word;
  logic       ctrlByteWr;

  assign word       = addr[3:2];
  assign ctrlByteWr = wrEn && (word == 2'd2) && byteEn[3];

  always_comb begin
    strobes          = '0;
    strobes.data     = wrData;
    strobes.rdEn     = rdEn;
    strobes.rdWord   = word;
    strobes.baseBe   = (wrEn && word == 2'd0) ? byteEn : 4'b0000;
    strobes.lviWr    = wrEn && (word == 2'd1) && byteEn[1];
    if (wrEn && word == 2'd1 && byteEn[2])
      strobes.srClr  = wrData[SR_LSB +: SR_W] & SR_W1C;
    strobes.regReset = ctrlByteWr && wrData[CR_LSB + CR_RST];
    strobes.crWr     = ctrlByteWr && !wrData[CR_LSB + CR_RST];
  end
endmodule

// File: rtl/aud_dma_chan_dp.sv
module aud_dma_chan_dp
  import aud_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobes_t      strobes,
  input  logic              advance,
  input  logic              picbLoad,
  input  logic [15:0]       picbValue,
  input  logic              setCompl,
  input  logic              setLvCompl,
  input  logic              setFifoErr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [IDX_W-1:0]  civIdx,
  output logic [IDX_W-1:0]  lviIdx,
  output logic [IDX_W-1:0]  pivIdx,
  output logic [SR_W-1:0]   srBits,
  output logic [CR_W-1:0]   crBits
);
  logic [DATA_W-1:0] baseReg;
  logic [15:0]       picbReg;
  logic              halted;
  logic [SR_W-1:0]   eventBits;
  logic [SR_W-1:0]   eventSet;
  logic [DATA_W-1:0] word0, word1, word2;

  assign eventSet = {setFifoErr, setCompl, setLvCompl, 2'b00};
  assign srBits   = {eventBits[SR_W-1:2], (civIdx == lviIdx), halted};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg   <= '0;
      civIdx    <= '0;
      lviIdx    <= '0;
      pivIdx    <= '0;
      picbReg   <= '0;
      crBits    <= '0;
      halted    <= 1'b1;
      eventBits <= '0;
    end else begin
      halted    <= ~crBits[CR_RUN];
      // a hardware set wins over a same-cycle clear
      eventBits <= (eventSet | (eventBits & ~strobes.srClr)) & SR_W1C;
      if (strobes.regReset) begin
        baseReg <= '0;
        civIdx  <= '0;
        lviIdx  <= '0;
        pivIdx  <= '0;
        picbReg <= '0;
        crBits  <= crBits & CR_KEEP;
      end else begin
        for (int b = 0; b < 4; b++)
          if (strobes.baseBe[b]) baseReg[b*8 +: 8] <= strobes.data[b*8 +: 8];
        if (strobes.lviWr) lviIdx <= strobes.data[LVI_LSB +: IDX_W];
        if (strobes.crWr)
          crBits <= strobes.data[CR_LSB +: CR_W] & ~(CR_W'(1) << CR_RST);
        if (advance) begin
          civIdx <= pivIdx;
          pivIdx <= pivIdx + 1'b1;   // wraps at RING_DEPTH (power of two)
        end
        if (picbLoad) picbReg <= picbValue;
      end
    end
  end

  assign word0 = baseReg;
  assign word1 = {{(16-SR_W){1'b0}}, srBits,
                  {(8-IDX_W){1'b0}}, lviIdx,
                  {(8-IDX_W){1'b0}}, civIdx};
  assign word2 = {{(8-CR_W){1'b0}}, crBits,
                  {(8-IDX_W){1'b0}}, pivIdx, picbReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdEn) begin
      unique case (strobes.rdWord)
        2'd0:    rdData <= word0;
        2'd1:    rdData <= word1;
        2'd2:    rdData <= word2;
        default: rdData <= '0;
      endcase
    end
  end

  assign irq = (srBits[SR_LVDONE] & crBits[CR_LVIE]) |
               (srBits[SR_DONE]   & crBits[CR_DONEIE]);
endmodule

// File: rtl/aud_dma_chan_regs.sv
module aud_dma_chan_regs
  import aud_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [3:0]        byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              advance,
  input  logic              picbLoad,
  input  logic [15:0]       picbValue,
  input  logic              setCompl,
  input  logic              setLvCompl,
  input  logic              setFifoErr,
  output logic              irq,
  output logic              runBm
);
  chanStrobes_t      strobes;
  logic [IDX_W-1:0]  civIdx, lviIdx, pivIdx;
  logic [SR_W-1:0]   srBits;
  logic [CR_W-1:0]   crBits;

  aud_dma_chan_ctrl ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .strobes(strobes)
  );

  aud_dma_chan_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .advance(advance),
    .picbLoad(picbLoad), .picbValue(picbValue), .setCompl(setCompl),
    .setLvCompl(setLvCompl), .setFifoErr(setFifoErr), .rdData(rdData),
    .irq(irq), .civIdx(civIdx), .lviIdx(lviIdx), .pivIdx(pivIdx),
    .srBits(srBits), .crBits(crBits)
  );

  assign runBm = crBits[CR_RUN];
endmodule

// File: rtl/aud_dma_chan_regs_chk.sv
module aud_dma_chan_regs_chk
  import aud_dma_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             advance,
  input logic             setCompl,
  input logic             irq,
  input chanStrobes_t     strobes,
  input logic [IDX_W-1:0] civ,
  input logic [IDX_W-1:0] piv,
  input logic [IDX_W-1:0] lvi,
  input logic [SR_W-1:0]  sr,
  input logic [CR_W-1:0]  cr
);
  assert_advance_R9: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strobes.regReset) |=>
      (civ == $past(piv)) && (piv == IDX_W'($past(piv) + 1'b1)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    setCompl |=> sr[SR_DONE]);

  assert_no_enable_no_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cr[CR_LVIE] && !cr[CR_DONEIE]) |-> !irq);

  assert_fifo_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!sr[SR_LVDONE] && !sr[SR_DONE]) |-> !irq);

  assert_reg_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regReset |=> (civ == '0) && (piv == '0) && (lvi == '0) &&
      !cr[CR_RUN] && !cr[CR_RST] &&
      (cr[CR_W-1:2] == $past(cr[CR_W-1:2])));

  assert_rst_bit_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cr[CR_RST]);
endmodule

bind aud_dma_chan_regs aud_dma_chan_regs_chk chk_i (
  .clk(clk), .rstN(rstN), .advance(advance), .setCompl(setCompl),
  .irq(irq), .strobes(strobes), .civ(civIdx), .piv(pivIdx), .lvi(lviIdx),
  .sr(srBits), .cr(crBits)
);

// File: tb/aud_dma_chan_regs_tb.sv
module aud_dma_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0, byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        advance = 1'b0, picbLoad = 1'b0;
  logic [15:0] picbValue = '0;
  logic        setCompl = 1'b0, setLvCompl = 1'b0, setFifoErr = 1'b0;
  logic        irq, runBm;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  aud_dma_chan_regs dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .advance(advance),
    .picbLoad(picbLoad), .picbValue(picbValue), .setCompl(setCompl),
    .setLvCompl(setLvCompl), .setFifoErr(setFifoErr), .irq(irq), .runBm(runBm)
  );

  // monitor: compare read data one cycle after the request
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: rdData actual %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [3:0] be,
                          input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; byteEn = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [31:0] e,
                         input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doAdvance(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); advance = 1'b1;
      @(negedge clk); advance = 1'b0;
    end
  endtask

  task automatic pulseSet(input int which);
    @(negedge clk);
    case (which)
      0: setLvCompl = 1'b1;
      1: setCompl   = 1'b1;
      default: setFifoErr = 1'b1;
    endcase
    @(negedge clk);
    setLvCompl = 1'b0; setCompl = 1'b0; setFifoErr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state, R1 unmapped word
    regRead(4'h0, 32'h0, "R2 base after reset");
    regRead(4'h4, 32'h0003_0000, "R2 word1 after reset");
    regRead(4'h8, 32'h0, "R2 word2 after reset");
    regRead(4'hC, 32'h0, "R1 unmapped word reads zero");
    checkBit("R7 irq after reset", irq, 1'b0);

    // R11 byte enables on base
    regWrite(4'h0, 4'b1111, 32'h1234_5678);
    regRead(4'h0, 32'h1234_5678, "R11 base full write");
    regWrite(4'h0, 4'b0010, 32'hFFFF_ABFF);
    regRead(4'h0, 32'h1234_AB78, "R11 base byte1 write");

    // R11 current index ignores writes, R4 equality drops
    regWrite(4'h4, 4'b0011, 32'h0000_03FF);
    regRead(4'h4, 32'h0001_0300, "R4 R11 lvi=3 civ unchanged");

    // R9 advance, R4 equality returns, R10 combined read
    doAdvance(4);
    regRead(4'h4, 32'h0003_0303, "R9 R10 civ=3 lvi=3 eq set");
    regRead(4'h8, 32'h0004_0000, "R9 piv=4");
    doAdvance(28);
    regRead(4'h8, 32'h0000_0000, "R9 piv wraps to 0");
    regRead(4'h4, 32'h0001_031F, "R9 civ=31");

    // R3 run clears halted; R5 writes to bits 0/1 ignored
    regWrite(4'h8, 4'b1000, 32'h0100_0000);
    checkBit("R3 runBm set", runBm, 1'b1);
    regRead(4'h4, 32'h0000_031F, "R3 halted cleared");
    regWrite(4'h4, 4'b0100, 32'h0003_0000);
    regRead(4'h4, 32'h0000_031F, "R5 read-only status bits ignore writes");

    // R11 position load
    @(negedge clk); picbLoad = 1'b1; picbValue = 16'h1234;
    @(negedge clk); picbLoad = 1'b0;
    regRead(4'h8, 32'h0100_1234, "R11 position loaded");

    // R7 completion cause
    pulseSet(1);
    checkBit("R7 completion without enable", irq, 1'b0);
    regRead(4'h4, 32'h0008_031F, "R6 completion bit set");
    regWrite(4'h8, 4'b1000, 32'h1100_0000);
    checkBit("R7 completion with enable", irq, 1'b1);
    regWrite(4'h4, 4'b0100, 32'h0008_0000);
    checkBit("R5 completion cleared irq", irq, 1'b0);

    // R7 last-valid completion cause
    pulseSet(0);
    checkBit("R7 lv completion without enable", irq, 1'b0);
    regWrite(4'h8, 4'b1000, 32'h0500_0000);
    checkBit("R7 lv completion with enable", irq, 1'b1);
    regWrite(4'h4, 4'b0100, 32'h0004_0000);
    checkBit("R5 lv completion cleared", irq, 1'b0);

    // R7 FIFO error never interrupts
    regWrite(4'h8, 4'b1000, 32'h1D00_0000);
    pulseSet(2);
    checkBit("R7 fifo error no irq", irq, 1'b0);
    regRead(4'h4, 32'h0010_031F, "R6 fifo bit set");
    regWrite(4'h4, 4'b0100, 32'h0010_0000);
    regRead(4'h4, 32'h0000_031F, "R5 fifo bit cleared");

    // R6 set and clear in the same cycle
    pulseSet(1);
    @(negedge clk);
    setCompl = 1'b1; wrEn = 1'b1; addr = 4'h4; byteEn = 4'b0100;
    wrData = 32'h0008_0000;
    @(negedge clk);
    setCompl = 1'b0; wrEn = 1'b0; byteEn = '0;
    regRead(4'h4, 32'h0008_031F, "R6 set beats clear");
    regWrite(4'h4, 4'b0100, 32'h0008_0000);
    regRead(4'h4, 32'h0000_031F, "R5 clear alone works");

    // R8 register reset keeps enables
    regWrite(4'h8, 4'b1000, 32'h0200_0000);
    checkBit("R8 run cleared", runBm, 1'b0);
    regRead(4'h0, 32'h0, "R8 base cleared");
    regRead(4'h4, 32'h0003_0000, "R8 indices cleared");
    regRead(4'h8, 32'h1C00_0000, "R8 enables kept, reset bit reads 0");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule